// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM. The host raises a request with an address, a read/write flag and write data, and holds it until the controller returns a one-cycle acknowledge. For a read, the acknowledge comes with the captured byte. The controller drives the memory's two chip enables (one active-low, one active-high), the active-low write enable and the active-low output enable from registers. The bidirectional data bus appears as separate output, input and drive-enable signals.

Every timing interval of the memory is turned into a whole number of clock cycles when the design is elaborated. Each interval is given in nanoseconds, the clock period is given in picoseconds, and the count is the ceiling of their ratio. This covers the access times, the write pulse, data setup and hold, the address hold after a write, the output turn-off time and the cycle time. A separate level command puts the memory into a low-power retention state, with the active-high enable held low. When the command is withdrawn, the controller waits one full cycle time before it starts another access.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the controller holds mem_ce_n=1, mem_ce=1, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and host_ack=0.
- R2: An accepted read drives mem_ce_n=0, mem_ce=1, mem_we_n=1 and mem_oe_n=0 together with the address in the accept cycle. The byte on mem_dq_in is captured N_RD cycles later, where N_RD = max(ceil(T_AA/T), ceil(T_OE/T)). host_ack and host_rdata appear in that same cycle, so a read requested while idle is acknowledged N_RD+1 rising edges after host_req is raised.
- R3: An accepted write drives the address, the data, mem_dq_oe=1 and mem_oe_n=1 one cycle before mem_we_n falls. mem_we_n then stays low for max(ceil(T_WP/T), ceil(T_DS/T)) cycles with address and data unchanged.
- R4: After mem_we_n rises, the address, the data and the bus drive are held for max(ceil(T_WR/T), ceil(T_DH/T)) cycles before they change.
- R5: Two successive access starts (the chip becoming selected) are at least ceil(T_CYC/T) cycles apart.
- R6: mem_dq_oe is never high while mem_oe_n is low. mem_dq_oe rises no sooner than ceil(T_OZ/T) cycles after mem_oe_n rises.
- R7: host_ack is a one-cycle pulse. A request is accepted only in the idle state, and each request causes exactly one memory access.
- R8: While ret_cmd is high and the controller has entered retention, mem_ce=0, mem_ce_n=1, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R9: A request made during retention is not served until ret_cmd falls. The next access then starts no sooner than ceil(T_CYC/T) cycles after mem_ce rises again.
- R10: When ret_cmd and host_req are both high in the idle state, retention is entered first and the request waits.
- R11: A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request, held until host_ack |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Request address |
| host_wdata | input | DATA_W | Write data |
| ret_cmd | input | 1 | Level command for retention |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Captured read byte |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable, low in retention |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable of the data bus |

## Verification
The retention command and a host request can reach the idle sequencer in the same cycle. Retention must win, and the request must wait through the whole exit interval. The bench raises both in one cycle and checks that the active-high enable falls while no access starts. It then drops the command and checks that the pending request starts only after a full cycle time. The acknowledge latency from the drop of the command is compared with a value computed from the timing constants. A behavioural memory model in the bench returns corrupted data when a read is sampled too early, and it checks every write pulse, hold interval, turnaround gap and cycle spacing.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_RECOV,
    ST_RET,
    ST_RETX
  } sramc_state_e;

  // ceiling of an interval in ns over a clock period in ps
  function automatic int ns2cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  // the count only moves down between loads (supports R2-style interval widths)
  assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(load) && !$past(rst) |-> cnt <= $past(cnt));

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              sample,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] host_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr <= host_addr;
      if (host_write) begin
        mem_dq_out <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (sample) begin
      host_rdata <= mem_dq_in;
    end
  end

  // address and write data change only when a request is taken (R4)
  assert_addr_held_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(accept) && !$past(rst) |-> $stable(mem_addr) && $stable(mem_dq_out));

endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int N_RD   = 38,
  parameter int N_WP   = 23,
  parameter int N_WH   = 3,
  parameter int N_RREC = 13,
  parameter int N_WREC = 11,
  parameter int N_CYC  = 38,
  parameter int N_OZ   = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_write,
  input  logic             ret_cmd,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             sample,
  output logic             ack,
  output logic             ce_n,
  output logic             ce,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  sramc_state_e st;

  assign accept = (st == ST_IDLE) && !ret_cmd && host_req;
  assign sample = (st == ST_RD) && tmr_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE:   if (accept && !host_write) begin
                   tmr_load = 1'b1; tmr_val = CNT_W'(N_RD - 1);
                 end
      ST_RD:     if (tmr_done) begin
                   tmr_load = 1'b1; tmr_val = CNT_W'(N_RREC - 1);
                 end
      ST_WSET:   begin
                   tmr_load = 1'b1; tmr_val = CNT_W'(N_WP - 1);
                 end
      ST_WPULSE: if (tmr_done) begin
                   tmr_load = 1'b1; tmr_val = CNT_W'(N_WH - 1);
                 end
      ST_WHOLD:  if (tmr_done) begin
                   tmr_load = 1'b1; tmr_val = CNT_W'(N_WREC - 1);
                 end
      ST_RET:    if (!ret_cmd) begin
                   tmr_load = 1'b1; tmr_val = CNT_W'(N_CYC - 1);
                 end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ce_n  <= 1'b1;
      ce    <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (ret_cmd) begin
            ce <= 1'b0;
            st <= ST_RET;
          end else if (host_req) begin
            ce_n <= 1'b0;
            if (host_write) begin
              dq_oe <= 1'b1;
              st    <= ST_WSET;
            end else begin
              oe_n <= 1'b0;
              st   <= ST_RD;
            end
          end
        end
        ST_RD: if (tmr_done) begin
          ack  <= 1'b1;
          ce_n <= 1'b1;
          oe_n <= 1'b1;
          st   <= ST_RECOV;
        end
        ST_WSET: begin
          we_n <= 1'b0;
          st   <= ST_WPULSE;
        end
        ST_WPULSE: if (tmr_done) begin
          we_n <= 1'b1;
          st   <= ST_WHOLD;
        end
        ST_WHOLD: if (tmr_done) begin
          ce_n  <= 1'b1;
          dq_oe <= 1'b0;
          ack   <= 1'b1;
          st    <= ST_RECOV;
        end
        ST_RECOV: if (tmr_done) st <= ST_IDLE;
        ST_RET: if (!ret_cmd) begin
          ce <= 1'b1;
          st <= ST_RETX;
        end
        ST_RETX: if (tmr_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // checker counter: cycles that output enable has been high, saturating
  logic [CNT_W-1:0] oz_gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      oz_gap <= CNT_W'(N_OZ);
    end else if (!oe_n) begin
      oz_gap <= '0;
    end else if (oz_gap < CNT_W'(N_OZ)) begin
      oz_gap <= oz_gap + 1'b1;
    end
  end

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> oz_gap >= CNT_W'(N_OZ));

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_we_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && ce && dq_oe && oe_n));

  assert_we_rise_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (!ce_n && dq_oe));

  assert_retention_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !ce |-> (ce_n && we_n && oe_n && !dq_oe));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 4000,
  parameter int T_CYC_NS = 150,
  parameter int T_AA_NS  = 150,
  parameter int T_OE_NS  = 70,
  parameter int T_WP_NS  = 90,
  parameter int T_DS_NS  = 60,
  parameter int T_DH_NS  = 5,
  parameter int T_WR_NS  = 10,
  parameter int T_OZ_NS  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              ret_cmd,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int N_CYC  = imax(ns2cyc(T_CYC_NS, CLK_PS), 1);
  localparam int N_RD   = imax(imax(ns2cyc(T_AA_NS, CLK_PS), ns2cyc(T_OE_NS, CLK_PS)), 1);
  localparam int N_WP   = imax(imax(ns2cyc(T_WP_NS, CLK_PS), ns2cyc(T_DS_NS, CLK_PS)), 1);
  localparam int N_WH   = imax(imax(ns2cyc(T_WR_NS, CLK_PS), ns2cyc(T_DH_NS, CLK_PS)), 1);
  localparam int N_OZ   = imax(ns2cyc(T_OZ_NS, CLK_PS), 1);
  localparam int N_RREC = imax(imax(N_OZ, N_CYC - N_RD), 1);
  localparam int N_WREC = imax(N_CYC - (1 + N_WP + N_WH), 1);
  localparam int N_MAX  = imax(imax(imax(N_CYC, N_RD), imax(N_WP, N_WH)),
                               imax(N_RREC, N_WREC));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  if (CLK_PS < 1 || ns2cyc(T_CYC_NS, CLK_PS) < 1 || ns2cyc(T_AA_NS, CLK_PS) < 1
      || ns2cyc(T_WP_NS, CLK_PS) < 1) begin : g_bad_timing
    $error("timing count below one clock cycle");
  end

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             accept;
  logic             sample;

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sramc_fsm #(
    .CNT_W  (CNT_W),
    .N_RD   (N_RD),
    .N_WP   (N_WP),
    .N_WH   (N_WH),
    .N_RREC (N_RREC),
    .N_WREC (N_WREC),
    .N_CYC  (N_CYC),
    .N_OZ   (N_OZ)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_write (host_write),
    .ret_cmd    (ret_cmd),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .sample     (sample),
    .ack        (host_ack),
    .ce_n       (mem_ce_n),
    .ce         (mem_ce),
    .we_n       (mem_we_n),
    .oe_n       (mem_oe_n),
    .dq_oe      (mem_dq_oe)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .sample     (sample),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .host_rdata (host_rdata)
  );

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int TNS = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_req, host_write, ret_cmd;
  logic [12:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .ret_cmd(ret_cmd),
    .host_ack(host_ack), .host_rdata(host_rdata), .mem_ce_n(mem_ce_n),
    .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  function automatic int cdiv(input int ns);
    return (ns + TNS - 1) / TNS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic logic [7:0] init_byte(input logic [12:0] a);
    return a[7:0] ^ {3'b101, a[12:8]};
  endfunction
  function automatic int rd_lat();
    return mx(cdiv(150), cdiv(70)) + 1;
  endfunction
  function automatic int wr_lat();
    return mx(cdiv(90), cdiv(60)) + mx(cdiv(10), cdiv(5)) + 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural memory model with timing monitors
  logic [7:0] mem_model [int];
  logic [7:0] shadow [int];
  int addr_cnt, oe_cnt, dat_cnt, we_cnt, since_start, since_ce_rise, since_oe_rise, hold_cnt;
  bit hold_on;
  logic [12:0] p_addr, h_addr;
  logic [7:0]  p_dout, h_data;
  logic p_oe_n, p_we_n, p_doe, p_act, p_ce;

  function automatic logic [7:0] stored(input logic [12:0] a);
    return mem_model.exists(int'(a)) ? mem_model[int'(a)] : init_byte(a);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      addr_cnt = 1; oe_cnt = 0; dat_cnt = 1; we_cnt = 0; hold_on = 0; hold_cnt = 0;
      since_start = 1000; since_ce_rise = 1000; since_oe_rise = 1000;
      p_addr = mem_addr; p_dout = mem_dq_out; p_oe_n = 1; p_we_n = 1;
      p_doe = 0; p_act = 0; p_ce = 1;
      mem_dq_in = 8'h00;
    end else begin
      logic act;
      act = !mem_ce_n && mem_ce;
      since_start++; since_ce_rise++; since_oe_rise++;
      addr_cnt = (mem_addr != p_addr) ? 1 : addr_cnt + 1;
      oe_cnt   = mem_oe_n ? 0 : (p_oe_n ? 1 : oe_cnt + 1);
      dat_cnt  = (mem_dq_out != p_dout || mem_dq_oe != p_doe) ? 1 : dat_cnt + 1;
      we_cnt   = mem_we_n ? we_cnt : (p_we_n ? 1 : we_cnt + 1);
      if (mem_ce && !p_ce) since_ce_rise = 1;
      if (mem_oe_n && !p_oe_n) since_oe_rise = 1;
      if (act && !p_act) begin
        check("R5 access spacing", ((since_start - 1) * TNS >= 150) ? 1 : 0, 1);
        check("R9 start after retention exit", ((since_ce_rise - 1) * TNS >= 150) ? 1 : 0, 1);
        since_start = 1;
        starts++;
      end
      if (mem_dq_oe && act && !mem_oe_n) check("R6 bus contention", 1, 0);
      if (mem_dq_oe && !p_doe)
        check("R6 turnaround gap", ((since_oe_rise - 1) * TNS >= 50) ? 1 : 0, 1);
      if (!mem_we_n && p_we_n)
        check("R3 setup at write fall", (addr_cnt >= 2 && act && mem_dq_oe) ? 1 : 0, 1);
      if (mem_we_n && !p_we_n) begin
        check("R3 write pulse width", (we_cnt * TNS >= 90) ? 1 : 0, 1);
        check("R3 data setup", ((dat_cnt - 1) * TNS >= 60) ? 1 : 0, 1);
        check("R3 address stable in pulse", (addr_cnt - 1 >= we_cnt) ? 1 : 0, 1);
        mem_model[int'(mem_addr)] = mem_dq_out;
        hold_on = 1; hold_cnt = 1; h_addr = mem_addr; h_data = mem_dq_out;
      end else if (hold_on) begin
        if (mem_addr == h_addr && mem_dq_out == h_data && mem_dq_oe && act) hold_cnt++;
        else begin
          check("R4 hold after write", (hold_cnt * TNS >= 10) ? 1 : 0, 1);
          hold_on = 0;
        end
      end
      if (act && mem_we_n && !mem_oe_n)
        mem_dq_in = (addr_cnt * TNS >= 150 && oe_cnt * TNS >= 70) ? stored(mem_addr)
                                                                  : ~stored(mem_addr);
      else
        mem_dq_in = 8'h00;
      p_addr = mem_addr; p_dout = mem_dq_out; p_oe_n = mem_oe_n; p_we_n = mem_we_n;
      p_doe = mem_dq_oe; p_act = act; p_ce = mem_ce;
    end
  end

  // called at a falling edge; returns at a falling edge
  task automatic do_op(input bit wr, input logic [12:0] a, input logic [7:0] d,
                       output logic [7:0] q, output int lat);
    int s0;
    s0 = starts;
    host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ack && lat < 2000);
    if (!host_ack) check("R7 ack timeout", 0, 1);
    q = host_rdata;
    host_req = 1'b0;
    @(negedge clk);
    check("R7 ack single cycle", int'(host_ack), 0);
    check("R7 one access per request", starts - s0, 1);
    if (wr) shadow[int'(a)] = d;
  endtask

  function automatic logic [7:0] expect_rd(input logic [12:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int lat, s0, c;
    bit seen;
    void'($urandom(32'd4417));
    rst = 1'b1; host_req = 0; host_write = 0; host_addr = '0; host_wdata = '0; ret_cmd = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ce_n", int'(mem_ce_n), 1);
    check("R1 ce", int'(mem_ce), 1);
    check("R1 we_n", int'(mem_we_n), 1);
    check("R1 oe_n", int'(mem_oe_n), 1);
    check("R1 dq_oe", int'(mem_dq_oe), 0);
    check("R1 ack", int'(host_ack), 0);
    repeat (40) @(negedge clk);

    do_op(0, 13'd0, 8'h00, q, lat);
    check("R2 read latency", lat, rd_lat());
    check("R2 read data", int'(q), int'(expect_rd(13'd0)));
    repeat (40) @(negedge clk);
    do_op(1, 13'h1FFF, 8'h3C, q, lat);
    check("R3 write latency", lat, wr_lat());
    repeat (40) @(negedge clk);
    do_op(0, 13'h1FFF, 8'h00, q, lat);
    check("R11 read after write", int'(q), 8'h3C);
    check("R2 read latency top address", lat, rd_lat());
    // back to back write then read at once
    do_op(1, 13'd5, 8'hA1, q, lat);
    do_op(0, 13'd5, 8'h00, q, lat);
    check("R11 back to back", int'(q), 8'hA1);
    do_op(1, 13'd6, 8'h5E, q, lat);

    // retention with a pending request (R8, R9)
    repeat (40) @(negedge clk);
    ret_cmd = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 ce low", int'(mem_ce), 0);
    check("R8 others idle", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'b1110);
    s0 = starts;
    host_req = 1'b1; host_write = 1'b0; host_addr = 13'd6;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (host_ack) seen = 1;
    end
    check("R9 request held in retention", int'(seen), 0);
    check("R9 no access in retention", starts - s0, 0);
    check("R8 ce still low", int'(mem_ce), 0);
    ret_cmd = 1'b0;
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!host_ack && c < 2000);
    check("R9 latency from exit", c, cdiv(150) + rd_lat() + 1);
    check("R9 held read data", int'(host_rdata), 8'h5E);
    host_req = 1'b0;
    @(negedge clk);

    // retention and request together in idle (R10)
    repeat (40) @(negedge clk);
    s0 = starts;
    ret_cmd = 1'b1; host_req = 1'b1; host_write = 1'b1; host_addr = 13'd9; host_wdata = 8'hC3;
    @(negedge clk);
    check("R10 retention first ce", int'(mem_ce), 0);
    check("R10 retention first ce_n", int'(mem_ce_n), 1);
    repeat (5) @(negedge clk);
    check("R10 no access yet", starts - s0, 0);
    ret_cmd = 1'b0;
    do_op(1, 13'd9, 8'hC3, q, lat);
    do_op(0, 13'd9, 8'h00, q, lat);
    check("R10 deferred write stored", int'(q), 8'hC3);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      bit wr;
      logic [12:0] a;
      logic [7:0] d;
      wr = 1'($urandom % 2);
      case ($urandom % 5)
        0: a = 13'd0;
        1: a = 13'h1FFF;
        default: a = 13'($urandom % 24 + 100);
      endcase
      d = 8'($urandom);
      repeat ($urandom % 4) @(negedge clk);
      if (i % 50 == 25) begin
        ret_cmd = 1'b1;
        repeat (20) @(negedge clk);
        check("R8 random retention ce", int'(mem_ce), 0);
        ret_cmd = 1'b0;
      end
      do_op(wr, a, d, q, lat);
      if (!wr) check("R11 random read", int'(q), int'(expect_rd(a)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule